// File: doc/BRIEF.md
# Shadow-Bank Exception Entry Unit

This unit steers a processor into and out of its privileged handler mode. When an exception, trap or interrupt is presented, it records where execution should resume, starts redirecting a fixed subset of the integer registers to their shadow copies, and sends fetch to a handler address. That address is a base register plus an offset chosen by the cause. A return strobe sends fetch back to the recorded address. Bit 0 of that address decides whether the registers go back to the normal bank.

The bank is chosen by a select bit for each register. Data is never copied between the banks. A four-state machine holds the bank state:
- ST_NORM: normal bank, unprivileged.
- ST_ENTER: privileged, but the switch to the shadow bank is still pending.
- ST_PRIV: privileged, shadow bank active.
- ST_LEAVE: unprivileged, but the switch back to the normal bank is still pending.

The transitions are:
- ST_NORM goes to ST_ENTER on an accepted entry or on an illegal return.
- ST_ENTER always goes to ST_PRIV.
- ST_PRIV stays in ST_PRIV on an entry, or on a return whose recorded address has bit 0 = 1.
- ST_PRIV goes to ST_LEAVE on a return whose recorded address has bit 0 = 0.
- ST_LEAVE always goes to ST_NORM.

Top module: `exc_bank_ctl`

## Requirements
- R1: During and after a synchronous reset, the state is ST_PRIV with the shadow bank active. pc_o = base_i + 0x001, npc_o = pc_o + 4, epc_o = 0, irq_arm_o = 0.
- R2: Only registers 8 to 14 and register 25 are ever redirected. The shadow value of bank_sel_o is 0x0200_7F00, and all other bits are always 0.
- R3: bank_sel_o changes one cycle after priv_o. On entry from ST_NORM, priv_o rises at the accepting edge and bank_sel_o follows at the next edge. On a leaving return, priv_o falls first and bank_sel_o clears one edge later.
- R4: An accepted entry sets pc_o = base_i + offset and npc_o = pc_o + 4. The offsets by ev_cause_i are: 0 interrupt 0x101, 1 alignment 0x301, 2 machine check 0x401, 3 illegal opcode 0x481, 4 privileged call 0x2001. Codes 5 to 7 use the illegal-opcode offset. Every offset has bit 0 set.
- R5: A privileged call (code 4) saves cur_pc_i + 4 in epc_o. Every other cause saves cur_pc_i.
- R6: An interrupt (code 0) taken in ST_PRIV leaves epc_o unchanged.
- R7: A return in ST_PRIV sets pc_o = epc_o and npc_o = epc_o + 4. If epc_o bit 0 is 0, it passes through ST_LEAVE to ST_NORM. If bit 0 is 1, it stays in ST_PRIV.
- R8: A return in ST_NORM is an illegal-opcode fault. It enters at offset 0x481, saves cur_pc_i, and raises ill_o for exactly one cycle.
- R9: An entry or return that arrives in ST_ENTER or ST_LEAVE is rejected. err_o is high for one cycle, and pc_o, npc_o and epc_o keep their values.
- R10: irq_arm_o is cleared by every accepted entry and set by every accepted return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| base_i | input | AW | Handler base register |
| ev_valid_i | input | 1 | Exception/trap/interrupt request strobe |
| ev_cause_i | input | 3 | Cause code (R4 encoding) |
| cur_pc_i | input | AW | PC of the instruction being interrupted |
| ret_i | input | 1 | Return-from-handler strobe |
| pc_o | output | AW | Redirect PC |
| npc_o | output | AW | Redirect PC + 4 |
| epc_o | output | AW | Saved restart address |
| priv_o | output | 1 | Privileged mode (ST_ENTER or ST_PRIV) |
| bank_sel_o | output | NREG | Per-register shadow select |
| irq_arm_o | output | 1 | Interrupt checking re-armed |
| ill_o | output | 1 | One-cycle illegal-return pulse |
| err_o | output | 1 | One-cycle rejected-request pulse |

## Verification
The properties assume that ev_valid_i and ret_i are never high in the same cycle. They also assume that the cause code and cur_pc_i are meaningful only while a strobe is high. The properties recover the state from the ports alone:
- a settled bank is priv_o agreeing with whether bank_sel_o is nonzero;
- a pending switch is the two disagreeing.

The bench drives at most one strobe per cycle from a single operation code, so the two strobes can never collide. Most stimulus leaves a quiet cycle after each request. The pending-state tests deliberately place a second request in the cycle right after a switch.

// File: rtl/exc_bank_pkg.sv
package exc_bank_pkg;

    typedef enum logic [1:0] {
        ST_NORM  = 2'd0,
        ST_ENTER = 2'd1,
        ST_PRIV  = 2'd2,
        ST_LEAVE = 2'd3
    } bank_st_e;

    localparam logic [2:0] CA_INTR  = 3'd0;
    localparam logic [2:0] CA_ALIGN = 3'd1;
    localparam logic [2:0] CA_MCHK  = 3'd2;
    localparam logic [2:0] CA_ILLOP = 3'd3;
    localparam logic [2:0] CA_PCALL = 3'd4;

    localparam int OFF_W = 16;

    function automatic logic [OFF_W-1:0] vec_offset(input logic [2:0] cause);
        logic [OFF_W-1:0] off;
        case (cause)
            CA_INTR:  off = 16'h0101;
            CA_ALIGN: off = 16'h0301;
            CA_MCHK:  off = 16'h0401;
            CA_PCALL: off = 16'h2001;
            default:  off = 16'h0481;
        endcase
        return off;
    endfunction

    function automatic logic cause_is_trap(input logic [2:0] cause);
        return cause == CA_PCALL;
    endfunction

    function automatic int unsigned shadow_bit(input int idx, input int lo,
                                               input int hi, input int extra);
        return ((idx >= lo && idx <= hi) || idx == extra) ? 1 : 0;
    endfunction

endpackage

// File: rtl/exc_bank_vector.sv
module exc_bank_vector
    import exc_bank_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] base_i,
    input  logic [2:0]    cause_i,
    output logic [AW-1:0] entry_pc_o
);
    logic [OFF_W-1:0] off;

    always_comb begin
        off        = vec_offset(cause_i);
        entry_pc_o = base_i + AW'(off);
    end
endmodule

// File: rtl/exc_bank_restart.sv
module exc_bank_restart
    import exc_bank_pkg::*;
#(
    parameter int AW    = 32,
    parameter int INSNB = 4
) (
    input  logic [2:0]    cause_i,
    input  logic [AW-1:0] pc_i,
    input  logic          in_priv_i,
    output logic          we_o,
    output logic [AW-1:0] nxt_o
);
    always_comb begin
        we_o  = !((cause_i == CA_INTR) && in_priv_i);
        nxt_o = cause_is_trap(cause_i) ? pc_i + AW'(INSNB) : pc_i;
    end
endmodule

// File: rtl/exc_bank_fsm.sv
module exc_bank_fsm
    import exc_bank_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ev_req_i,
    input  logic     ret_req_i,
    input  logic     saved_lsb_i,
    output bank_st_e state_o,
    output logic     take_entry_o,
    output logic     take_ill_o,
    output logic     take_ret_o,
    output logic     reject_o
);
    bank_st_e state_q, state_d;
    logic     busy;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PRIV;
        else        state_q <= state_d;
    end

    always_comb begin
        busy         = (state_q == ST_ENTER) || (state_q == ST_LEAVE);
        reject_o     = (ev_req_i || ret_req_i) && busy;
        take_entry_o = ev_req_i && !busy;
        take_ill_o   = ret_req_i && (state_q == ST_NORM);
        take_ret_o   = ret_req_i && (state_q == ST_PRIV);
        state_d      = state_q;
        unique case (state_q)
            ST_NORM:  if (take_entry_o || take_ill_o) state_d = ST_ENTER;
            ST_ENTER: state_d = ST_PRIV;
            ST_PRIV:  if (take_ret_o && !saved_lsb_i) state_d = ST_LEAVE;
            ST_LEAVE: state_d = ST_NORM;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/exc_bank_ctl.sv
module exc_bank_ctl
    import exc_bank_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int          NREG     = 32,
    parameter int          SH_LO    = 8,
    parameter int          SH_HI    = 14,
    parameter int          SH_EXTRA = 25,
    parameter int          INSNB    = 4,
    parameter logic [15:0] RST_VEC  = 16'h0001
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   base_i,
    input  logic            ev_valid_i,
    input  logic [2:0]      ev_cause_i,
    input  logic [AW-1:0]   cur_pc_i,
    input  logic            ret_i,
    output logic [AW-1:0]   pc_o,
    output logic [AW-1:0]   npc_o,
    output logic [AW-1:0]   epc_o,
    output logic            priv_o,
    output logic [NREG-1:0] bank_sel_o,
    output logic            irq_arm_o,
    output logic            ill_o,
    output logic            err_o
);
    localparam logic [AW-1:0] STEP = AW'(INSNB);

    bank_st_e        state;
    logic            take_entry, take_ill, take_ret, reject;
    logic [2:0]      eff_cause;
    logic [AW-1:0]   entry_pc, epc_nxt;
    logic            epc_we, shadow_on;

    exc_bank_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_req_i     (ev_valid_i),
        .ret_req_i    (ret_i),
        .saved_lsb_i  (epc_o[0]),
        .state_o      (state),
        .take_entry_o (take_entry),
        .take_ill_o   (take_ill),
        .take_ret_o   (take_ret),
        .reject_o     (reject)
    );

    assign eff_cause = take_ill ? CA_ILLOP : ev_cause_i;

    exc_bank_vector #(.AW(AW)) u_vec (
        .base_i     (base_i),
        .cause_i    (eff_cause),
        .entry_pc_o (entry_pc)
    );

    exc_bank_restart #(.AW(AW), .INSNB(INSNB)) u_rst (
        .cause_i   (eff_cause),
        .pc_i      (cur_pc_i),
        .in_priv_i (state == ST_PRIV),
        .we_o      (epc_we),
        .nxt_o     (epc_nxt)
    );

    // Output registers: redirect PCs, saved address, pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_o      <= base_i + AW'(RST_VEC);
            npc_o     <= base_i + AW'(RST_VEC) + STEP;
            epc_o     <= '0;
            irq_arm_o <= 1'b0;
            ill_o     <= 1'b0;
            err_o     <= 1'b0;
        end else begin
            ill_o <= take_ill;
            err_o <= reject;
            if (take_entry || take_ill) begin
                pc_o      <= entry_pc;
                npc_o     <= entry_pc + STEP;
                irq_arm_o <= 1'b0;
                if (epc_we) epc_o <= epc_nxt;
            end else if (take_ret) begin
                pc_o      <= epc_o;
                npc_o     <= epc_o + STEP;
                irq_arm_o <= 1'b1;
            end
        end
    end

    assign priv_o    = (state == ST_ENTER) || (state == ST_PRIV);
    assign shadow_on = (state == ST_PRIV) || (state == ST_LEAVE);

    for (genvar gi = 0; gi < NREG; gi++) begin : g_sel
        if (shadow_bit(gi, SH_LO, SH_HI, SH_EXTRA) != 0) begin : g_bank
            assign bank_sel_o[gi] = shadow_on;
        end else begin : g_shared
            assign bank_sel_o[gi] = 1'b0;
        end
    end
endmodule

// File: rtl/exc_bank_chk.sv
module exc_bank_chk
    import exc_bank_pkg::*;
#(
    parameter int AW       = 32,
    parameter int NREG     = 32,
    parameter int SH_LO    = 8,
    parameter int SH_HI    = 14,
    parameter int SH_EXTRA = 25,
    parameter int INSNB    = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   base_i,
    input logic            ev_valid_i,
    input logic [2:0]      ev_cause_i,
    input logic [AW-1:0]   cur_pc_i,
    input logic            ret_i,
    input logic [AW-1:0]   pc_o,
    input logic [AW-1:0]   npc_o,
    input logic [AW-1:0]   epc_o,
    input logic            priv_o,
    input logic [NREG-1:0] bank_sel_o,
    input logic            irq_arm_o,
    input logic            ill_o,
    input logic            err_o
);
    logic [NREG-1:0] mask;
    always_comb begin
        for (int i = 0; i < NREG; i++)
            mask[i] = shadow_bit(i, SH_LO, SH_HI, SH_EXTRA) != 0;
    end

    logic sel_any, settled_sh, settled_nm, pending;
    assign sel_any    = |bank_sel_o;
    assign settled_sh = priv_o && sel_any;
    assign settled_nm = !priv_o && !sel_any;
    assign pending    = priv_o != sel_any;

    a_r3_sel_lags: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(priv_o) |-> bank_sel_o == '0);
    a_r3_sel_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(priv_o) |=> bank_sel_o == mask);
    a_r4_mchk_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid_i && ev_cause_i == CA_MCHK && !pending)
        |=> (pc_o == $past(base_i) + AW'(16'h0401)) && (npc_o == pc_o + AW'(INSNB)));
    a_r5_pcall_epc: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid_i && ev_cause_i == CA_PCALL && !pending)
        |=> epc_o == $past(cur_pc_i) + AW'(INSNB));
    a_r6_intr_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid_i && ev_cause_i == CA_INTR && settled_sh) |=> $stable(epc_o));
    a_r7_ret_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && settled_sh) |=> pc_o == $past(epc_o));
    a_r7_ret_stay: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && settled_sh && epc_o[0]) |=> priv_o && bank_sel_o == mask);
    a_r8_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && settled_nm) |=> ill_o && priv_o && epc_o == $past(cur_pc_i));
    a_r9_reject: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_valid_i || ret_i) && pending) |=> err_o && $stable(pc_o) && $stable(epc_o));
    a_r10_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && settled_sh) |=> irq_arm_o);
endmodule

bind exc_bank_ctl exc_bank_chk #(
    .AW(AW), .NREG(NREG), .SH_LO(SH_LO), .SH_HI(SH_HI),
    .SH_EXTRA(SH_EXTRA), .INSNB(INSNB)
) u_chk (
    .clk(clk), .rst_n(rst_n), .base_i(base_i), .ev_valid_i(ev_valid_i),
    .ev_cause_i(ev_cause_i), .cur_pc_i(cur_pc_i), .ret_i(ret_i),
    .pc_o(pc_o), .npc_o(npc_o), .epc_o(epc_o), .priv_o(priv_o),
    .bank_sel_o(bank_sel_o), .irq_arm_o(irq_arm_o), .ill_o(ill_o),
    .err_o(err_o)
);

// File: tb/sim_exc_bank_ctl.sv
`timescale 1ns/1ps
module sim_exc_bank_ctl;
    localparam int AW = 32;
    localparam int NREG = 32;
    localparam logic [31:0] MASK = 32'h0200_7F00;
    localparam int NV = 18;

    // op: 1 = entry, 2 = return
    localparam logic [1:0]  V_OP [NV] = '{1,2,1,1,2,1,2,1,2,2,2,1,2,2,1,2,1,2};
    localparam logic [2:0]  V_CA [NV] = '{4,0,2,0,0,0,0,1,0,0,0,2,0,0,6,0,3,0};
    localparam logic [31:0] V_PC [NV] = '{
        32'h2000, 0, 32'h3000, 32'h4444, 0, 32'h5000, 0, 32'h6000, 0,
        32'h7000, 0, 32'h8001, 0, 0, 32'hA000, 0, 32'hB000, 0};
    localparam logic [31:0] E_PC [NV] = '{
        32'h12001, 32'h2004, 32'h10401, 32'h10101, 32'h3000, 32'h10101,
        32'h5000, 32'h10301, 32'h6000, 32'h10481, 32'h7000, 32'h10401,
        32'h8001, 32'h8001, 32'h10481, 32'hA000, 32'h10481, 32'hB000};
    localparam logic [31:0] E_EPC [NV] = '{
        32'h2004, 32'h2004, 32'h3000, 32'h3000, 32'h3000, 32'h5000,
        32'h5000, 32'h6000, 32'h6000, 32'h7000, 32'h7000, 32'h8001,
        32'h8001, 32'h8001, 32'hA000, 32'hA000, 32'hB000, 32'hB000};
    localparam logic E_PRIV [NV] = '{1,0,1,1,0,1,0,1,0,1,0,1,1,1,1,0,1,0};
    localparam logic E_ARM  [NV] = '{0,1,0,0,1,0,1,0,1,0,1,0,1,1,0,1,0,1};

    logic            clk = 0, rst_n = 0;
    logic [AW-1:0]   base = 32'h10000, cur_pc = 0;
    logic            ev_valid = 0, ret = 0;
    logic [2:0]      cause = 0;
    logic [AW-1:0]   pc, npc, epc;
    logic            priv, arm, ill, err;
    logic [NREG-1:0] sel;
    int total = 0, bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    exc_bank_ctl u0 (
        .clk(clk), .rst_n(rst_n), .base_i(base), .ev_valid_i(ev_valid),
        .ev_cause_i(cause), .cur_pc_i(cur_pc), .ret_i(ret), .pc_o(pc),
        .npc_o(npc), .epc_o(epc), .priv_o(priv), .bank_sel_o(sel),
        .irq_arm_o(arm), .ill_o(ill), .err_o(err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [2:0] ca, input logic [31:0] p);
        ev_valid = (op == 2'd1);
        ret      = (op == 2'd2);
        cause    = ca;
        cur_pc   = p;
        @(negedge clk);
        ev_valid = 0;
        ret      = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pc", pc, 32'h10001);
        chk("R1 npc", npc, 32'h10005);
        chk("R1 epc", epc, 0);
        chk("R1 priv", {31'b0, priv}, 1);
        chk("R1 arm", {31'b0, arm}, 0);
        chk("R1 sel", sel, MASK);
        rst_n = 1;
        @(negedge clk);

        // vector table
        for (int i = 0; i < NV; i++) begin
            drive(V_OP[i], V_CA[i], V_PC[i]);
            @(negedge clk);
            chk(V_OP[i] == 2 ? "R7 pc" : "R4 pc", pc, E_PC[i]);
            chk(V_OP[i] == 2 ? "R7 npc" : "R4 npc", npc, E_PC[i] + 4);
            chk("R5 R6 epc", epc, E_EPC[i]);
            chk("R7 R8 priv", {31'b0, priv}, {31'b0, E_PRIV[i]});
            chk("R10 arm", {31'b0, arm}, {31'b0, E_ARM[i]});
            chk("R2 sel", sel, E_PRIV[i] ? MASK : 32'h0);
        end

        // R3 lag on entry from the normal bank, R2 bit positions
        drive(2'd1, 3'd2, 32'hC000);
        chk("R3 priv first", {31'b0, priv}, 1);
        chk("R3 sel lags", sel, 0);
        @(negedge clk);
        chk("R3 sel follows", sel, MASK);
        chk("R2 bit7", {31'b0, sel[7]}, 0);
        chk("R2 bit8", {31'b0, sel[8]}, 1);
        chk("R2 bit14", {31'b0, sel[14]}, 1);
        chk("R2 bit15", {31'b0, sel[15]}, 0);
        chk("R2 bit25", {31'b0, sel[25]}, 1);
        chk("R2 bit24", {31'b0, sel[24]}, 0);

        // R9 request during pending leave
        drive(2'd2, 3'd0, 32'h0);
        chk("R3 leave priv", {31'b0, priv}, 0);
        chk("R3 leave sel", sel, MASK);
        drive(2'd1, 3'd1, 32'hD000);
        chk("R9 err", {31'b0, err}, 1);
        chk("R9 pc", pc, 32'hC000);
        chk("R9 npc", npc, 32'hC004);
        chk("R9 epc", epc, 32'hC000);
        @(negedge clk);
        chk("R9 err pulse", {31'b0, err}, 0);
        chk("R9 settled", sel, 0);

        // R8 illegal return pulse, R9 during pending enter
        drive(2'd2, 3'd0, 32'hE000);
        chk("R8 ill", {31'b0, ill}, 1);
        chk("R8 pc", pc, 32'h10481);
        chk("R8 epc", epc, 32'hE000);
        drive(2'd1, 3'd4, 32'hF000);
        chk("R8 ill pulse", {31'b0, ill}, 0);
        chk("R9 err enter", {31'b0, err}, 1);
        chk("R9 epc enter", epc, 32'hE000);
        chk("R9 pc enter", pc, 32'h10481);

        // R1 reset again with another base
        base = 32'h20000;
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 pc rebase", pc, 32'h20001);
        chk("R1 npc rebase", npc, 32'h20005);
        chk("R1 sel rebase", sel, MASK);
        chk("R1 epc rebase", epc, 0);
        rst_n = 1;
        @(negedge clk);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule